// File: doc/BRIEF.md
# Data Space Address Decoder with External Memory Bus

This block sits between the load/store port of an 8-bit microcontroller core and the places a data byte can live. It takes a 16-bit data address and classifies it into one of four windows. The three on-chip windows are the working register file, the I/O register window and the on-chip data SRAM. Every address past the SRAM goes to an external memory bus. For an on-chip target, the block raises that target's select, gives the offset within the window and returns the target's read data in the same cycle.

Only external accesses cost time. When the external-memory enable input is set, an off-chip access stalls the core by holding `ready` low. The stall lasts one cycle per byte, or two cycles when the wait-state input is set. During the stall the block drives an address that does not change, the write data and active-low read or write strobes. It captures the external read data on the last stall cycle.

When the enable input is clear, an address above the on-chip range does nothing: no stall, no strobe, reads return zero and writes are dropped. Multi-byte transfers such as a two-byte stack push are issued as separate byte requests, so each byte pays its own penalty.

Top module: `dspace_decoder`

## Requirements
- R1: A request with address 0x0000–0x001F raises `rf_sel` alone, gives `loc_addr` equal to the address, returns `rf_rdata` on `rdata`, and holds `ready` high in the same cycle.
- R2: A request with address 0x0020–0x005F raises `io_sel` alone, with `loc_addr` equal to the address minus 0x20, and returns `io_rdata` in the same cycle.
- R3: A request with address 0x0060–0x045F raises `sram_sel` alone, with `loc_addr` equal to the address minus 0x60, and returns `sram_rdata` in the same cycle. `loc_we` follows `we` for any on-chip target.
- R4: During any on-chip access, `xrd_n` and `xwr_n` stay high (inactive) and `xd_oe` stays low for the whole cycle.
- R5: With `ext_en`=1 and `wait_en`=0, a request to 0x0460–0xFFFF holds `ready` low for exactly one cycle and raises it in the second cycle.
- R6: With `ext_en`=1 and `wait_en`=1, an external request holds `ready` low for exactly two cycles and raises it in the third cycle.
- R7: During the stall cycles of an external access, exactly one strobe is low. For a read it is `xrd_n`. For a write it is `xwr_n`, with `xd_oe`=1 and `xd_out` equal to the write data. Both strobes are high in the cycle in which `ready` rises.
- R8: On an external read, `rdata` in the cycle in which `ready` rises equals the `xd_in` value present in the last stall cycle, whatever `xd_in` held in earlier stall cycles.
- R9: With `ext_en`=0, a request to 0x0460–0xFFFF does not stall (`ready`=1) and returns `rdata`=0x00. It raises no select, no strobe and no `loc_we`, and a write to it leaves no trace on the external pins.
- R10: While an external access is stalled, `xa` equals the request address and `xd_out` keeps the same value in every cycle.
- R11: Back-to-back external byte requests each pay their own penalty. A two-byte transfer stalls for two cycles in total without wait states and for four with them.
- R12: At most one of `rf_sel`, `io_sel` and `sram_sel` is high at any time, and none is high for an external address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_en | input | 1 | External memory enable bit from the control register |
| wait_en | input | 1 | Adds one wait cycle per external byte |
| req | input | 1 | Core load/store request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Data space byte address |
| wdata | input | 8 | Core write data |
| rdata | output | 8 | Read data to the core |
| ready | output | 1 | Access completes this cycle; low while stalled |
| rf_sel | output | 1 | Register file select |
| io_sel | output | 1 | I/O register window select |
| sram_sel | output | 1 | On-chip SRAM select |
| loc_addr | output | 10 | Offset inside the selected on-chip window |
| loc_we | output | 1 | Write enable to the selected on-chip target |
| rf_rdata | input | 8 | Register file read data |
| io_rdata | input | 8 | I/O register read data |
| sram_rdata | input | 8 | SRAM read data |
| xa | output | 16 | External address |
| xd_out | output | 8 | External write data |
| xd_oe | output | 1 | External data output enable |
| xd_in | input | 8 | External read data |
| xrd_n | output | 1 | External read strobe, active low |
| xwr_n | output | 1 | External write strobe, active low |

## Verification
The bench probes both edges of every window: 0x001F/0x0020, 0x005F/0x0060 and 0x045F/0x0460, plus 0xFFFF. A decoder with an off-by-one boundary would select the wrong target or stall where it should not. On external reads it changes `xd_in` on every stall cycle, so a design that samples on the first stall cycle or on the ready cycle returns the wrong byte. It counts the stall cycles with and without wait states, and across two requests issued back to back. A counter that is not cleared between bytes would shorten the second access. With the enable clear, it checks that an external write leaves the strobes idle and that a read returns zero without stalling the core.

// File: rtl/dspace_pkg.sv
package dspace_pkg;

  // Target window classification of a data address
  typedef enum logic [1:0] {
    RGN_RF   = 2'd0,
    RGN_IO   = 2'd1,
    RGN_SRAM = 2'd2,
    RGN_EXT  = 2'd3
  } region_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dspace_region_dec.sv
module dspace_region_dec
  import dspace_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned RF_SIZE   = 32,
  parameter int unsigned IO_SIZE   = 64,
  parameter int unsigned SRAM_SIZE = 1024,
  parameter int unsigned LOC_W     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [LOC_W-1:0]  loc_off,
  output logic              rf_hit,
  output logic              io_hit,
  output logic              sram_hit
);

  localparam int unsigned IO_BASE   = RF_SIZE;
  localparam int unsigned SRAM_BASE = RF_SIZE + IO_SIZE;
  localparam int unsigned EXT_BASE  = SRAM_BASE + SRAM_SIZE;

  always_comb begin
    if (addr < ADDR_W'(IO_BASE)) begin
      region  = RGN_RF;
      loc_off = LOC_W'(addr);
    end else if (addr < ADDR_W'(SRAM_BASE)) begin
      region  = RGN_IO;
      loc_off = LOC_W'(addr - ADDR_W'(IO_BASE));
    end else if (addr < ADDR_W'(EXT_BASE)) begin
      region  = RGN_SRAM;
      loc_off = LOC_W'(addr - ADDR_W'(SRAM_BASE));
    end else begin
      region  = RGN_EXT;
      loc_off = '0;
    end
  end

  assign rf_hit   = req && (region == RGN_RF);
  assign io_hit   = req && (region == RGN_IO);
  assign sram_hit = req && (region == RGN_SRAM);

  // Selects never overlap, and none is raised for an off-chip address
  assert_onehot_sel_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_hit, io_hit, sram_hit}));

  assert_ext_no_sel_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= ADDR_W'(EXT_BASE)) |-> !(rf_hit || io_hit || sram_hit));

endmodule

// File: rtl/dspace_ext_ctrl.sv
module dspace_ext_ctrl #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BASE_EXTRA = 1,
  parameter int unsigned WAIT_EXTRA = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wait_en,
  input  logic [DATA_W-1:0] xd_in,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] xa,
  output logic [DATA_W-1:0] xd_out,
  output logic              xd_oe,
  output logic              xrd_n,
  output logic              xwr_n
);

  localparam int unsigned CNT_W = $clog2(WAIT_EXTRA + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  need_q, need_now, need;
  logic [ADDR_W-1:0] xa_q;
  logic [DATA_W-1:0] wd_q, rd_q;
  logic              we_q, we_eff;
  logic              first, stall, latch_en, cap_en;

  // Cycle bookkeeping of one external byte access
  always_comb begin
    need_now = wait_en ? CNT_W'(WAIT_EXTRA) : CNT_W'(BASE_EXTRA);
    first    = (cnt_q == '0);
    need     = first ? need_now : need_q;
    done     = go && (cnt_q == need);
    stall    = go && !done;
    cnt_d    = stall ? cnt_q + CNT_W'(1) : '0;
    latch_en = go && first;
    cap_en   = stall && (cnt_q == need - CNT_W'(1));
    we_eff   = first ? we : we_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      need_q <= '0;
      xa_q   <= '0;
      wd_q   <= '0;
      we_q   <= 1'b0;
    end else if (latch_en) begin
      need_q <= need_now;
      xa_q   <= addr;
      wd_q   <= wdata;
      we_q   <= we;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (cap_en) begin
      rd_q <= xd_in;
    end
  end

  // Pin drive: address and data held from the first cycle of the access
  always_comb begin
    xa      = go ? (first ? addr : xa_q) : '0;
    xd_out  = (go && we_eff) ? (first ? wdata : wd_q) : '0;
    xd_oe   = stall && we_eff;
    xrd_n   = !(stall && !we_eff);
    xwr_n   = !(stall && we_eff);
    rd_data = rd_q;
  end

  // Strobes are never low together
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!xrd_n && !xwr_n));

  // Address and write data hold still while the core waits
  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!go || (xa == $past(xa) && xd_out == $past(xd_out))));

  // Without wait states the second cycle completes
  assert_nowait_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && first && !wait_en) |=> (!go || done));

  // With wait states the second cycle is still a stall
  assert_wait_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && first && wait_en) |=> (!go || !done));

  // Strobes inactive in the completing cycle
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (xrd_n && xwr_n && !xd_oe));

endmodule

// File: rtl/dspace_rd_mux.sv
module dspace_rd_mux
  import dspace_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  region_e           region,
  input  logic              ext_done,
  input  logic [DATA_W-1:0] rf_rdata,
  input  logic [DATA_W-1:0] io_rdata,
  input  logic [DATA_W-1:0] sram_rdata,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic [DATA_W-1:0] rdata
);

  always_comb begin
    unique case (region)
      RGN_RF:   rdata = rf_rdata;
      RGN_IO:   rdata = io_rdata;
      RGN_SRAM: rdata = sram_rdata;
      default:  rdata = ext_done ? ext_rdata : '0;
    endcase
  end

endmodule

// File: rtl/dspace_decoder.sv
module dspace_decoder
  import dspace_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned RF_SIZE    = 32,
  parameter int unsigned IO_SIZE    = 64,
  parameter int unsigned SRAM_SIZE  = 1024,
  parameter int unsigned BASE_EXTRA = 1,
  parameter int unsigned WAIT_EXTRA = 2,
  parameter int unsigned LOC_W      = $clog2(max3(RF_SIZE, IO_SIZE, SRAM_SIZE))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_en,
  input  logic              wait_en,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready,
  output logic              rf_sel,
  output logic              io_sel,
  output logic              sram_sel,
  output logic [LOC_W-1:0]  loc_addr,
  output logic              loc_we,
  input  logic [DATA_W-1:0] rf_rdata,
  input  logic [DATA_W-1:0] io_rdata,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic [ADDR_W-1:0] xa,
  output logic [DATA_W-1:0] xd_out,
  output logic              xd_oe,
  input  logic [DATA_W-1:0] xd_in,
  output logic              xrd_n,
  output logic              xwr_n
);

  localparam int unsigned SYNC_STAGES = 2;

  // Reset: asserted asynchronously, released on a clock edge
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_q_n = rst_pipe[SYNC_STAGES-1];

  region_e           region;
  logic [LOC_W-1:0]  loc_off;
  logic              rf_hit, io_hit, sram_hit;
  logic              ext_hit, ext_go, ext_done;
  logic [DATA_W-1:0] ext_rdata;

  dspace_region_dec #(
    .ADDR_W   (ADDR_W),
    .RF_SIZE  (RF_SIZE),
    .IO_SIZE  (IO_SIZE),
    .SRAM_SIZE(SRAM_SIZE),
    .LOC_W    (LOC_W)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .req     (req),
    .addr    (addr),
    .region  (region),
    .loc_off (loc_off),
    .rf_hit  (rf_hit),
    .io_hit  (io_hit),
    .sram_hit(sram_hit)
  );

  assign ext_hit = req && (region == RGN_EXT);
  assign ext_go  = ext_hit && ext_en;

  dspace_ext_ctrl #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE_EXTRA(BASE_EXTRA),
    .WAIT_EXTRA(WAIT_EXTRA)
  ) u_ext (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .go     (ext_go),
    .we     (we),
    .addr   (addr),
    .wdata  (wdata),
    .wait_en(wait_en),
    .xd_in  (xd_in),
    .done   (ext_done),
    .rd_data(ext_rdata),
    .xa     (xa),
    .xd_out (xd_out),
    .xd_oe  (xd_oe),
    .xrd_n  (xrd_n),
    .xwr_n  (xwr_n)
  );

  dspace_rd_mux #(
    .DATA_W(DATA_W)
  ) u_mux (
    .region    (region),
    .ext_done  (ext_done),
    .rf_rdata  (rf_rdata),
    .io_rdata  (io_rdata),
    .sram_rdata(sram_rdata),
    .ext_rdata (ext_rdata),
    .rdata     (rdata)
  );

  assign rf_sel   = rf_hit;
  assign io_sel   = io_hit;
  assign sram_sel = sram_hit;
  assign loc_addr = loc_off;
  assign loc_we   = req && we && !ext_hit;
  assign ready    = ext_go ? ext_done : 1'b1;

  // On-chip access: no strobe and no stall
  assert_internal_quiet_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rf_sel || io_sel || sram_sel) |-> (xrd_n && xwr_n && !xd_oe && ready));

  // Disabled external window: no stall, zero data, pins idle
  assert_disabled_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ext_hit && !ext_en) |-> (ready && rdata == '0 && xrd_n && xwr_n && !loc_we));

  // A stalled external access keeps a strobe low
  assert_stall_strobe_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req && !ready) |-> (!xrd_n || !xwr_n));

endmodule

// File: tb/dspace_decoder_bench.sv
`timescale 1ns/1ps
module dspace_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_en, wait_en, req, we;
  logic [15:0] addr;
  logic [7:0]  wdata, rdata;
  logic        ready, rf_sel, io_sel, sram_sel, loc_we;
  logic [9:0]  loc_addr;
  logic [7:0]  rf_rdata, io_rdata, sram_rdata, xd_in, xd_out;
  logic [15:0] xa;
  logic        xd_oe, xrd_n, xwr_n;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dspace_decoder u_dspace_decoder (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .wait_en(wait_en),
    .req(req), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ready(ready), .rf_sel(rf_sel), .io_sel(io_sel), .sram_sel(sram_sel),
    .loc_addr(loc_addr), .loc_we(loc_we), .rf_rdata(rf_rdata),
    .io_rdata(io_rdata), .sram_rdata(sram_rdata), .xa(xa), .xd_out(xd_out),
    .xd_oe(xd_oe), .xd_in(xd_in), .xrd_n(xrd_n), .xwr_n(xwr_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    #2;
    check(ready == 1'b1, "R4 reset ready", ready, 1);
    check({xrd_n, xwr_n, xd_oe} == 3'b110, "R4 reset strobes", {xrd_n, xwr_n, xd_oe}, 3'b110);
    check({rf_sel, io_sel, sram_sel} == 3'b000, "R12 reset selects", {rf_sel, io_sel, sram_sel}, 0);
  endtask

  // One on-chip access; sel_exp is {rf,io,sram}
  task automatic t_internal(input logic [15:0] a, input logic w, input logic [2:0] sel_exp,
                            input logic [9:0] off_exp, input logic [7:0] rd_exp, input string tag);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = 8'h3C;
    #2;
    check({rf_sel, io_sel, sram_sel} == sel_exp, {tag, " select"}, {rf_sel, io_sel, sram_sel}, sel_exp);
    check(loc_addr == off_exp, {tag, " offset"}, loc_addr, off_exp);
    check(ready == 1'b1, {tag, " ready R4"}, ready, 1);
    check({xrd_n, xwr_n, xd_oe} == 3'b110, {tag, " strobes R4"}, {xrd_n, xwr_n, xd_oe}, 3'b110);
    check(loc_we == w, {tag, " loc_we R3"}, loc_we, w);
    if (!w) check(rdata == rd_exp, {tag, " rdata"}, rdata, rd_exp);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  // One external byte access; leaves req high so calls can chain
  task automatic ext_byte(input logic [15:0] a, input logic w, input logic [7:0] d,
                          input int n_extra, input string tag, output int stalls);
    logic [7:0] first_xd;
    stalls = 0;
    req = 1'b1; we = w; addr = a; wdata = d;
    for (int k = 0; k < 6; k++) begin
      xd_in = (k == n_extra - 1) ? d : ~d;
      #2;
      if (ready) begin
        check(xrd_n && xwr_n && !xd_oe, {tag, " idle on done R7"}, {xrd_n, xwr_n, xd_oe}, 3'b110);
        if (!w) check(rdata == d, {tag, " read data R8"}, rdata, d);
        break;
      end
      stalls++;
      check(xa == a, {tag, " address R10"}, xa, a);
      if (w) begin
        check(!xwr_n && xrd_n && xd_oe, {tag, " write strobe R7"}, {xrd_n, xwr_n, xd_oe}, 3'b101);
        if (k == 0) first_xd = xd_out;
        check(xd_out == d && xd_out == first_xd, {tag, " wdata R10"}, xd_out, d);
      end else begin
        check(!xrd_n && xwr_n && !xd_oe, {tag, " read strobe R7"}, {xrd_n, xwr_n, xd_oe}, 3'b010);
      end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic t_ext_nowait();
    int s;
    ext_en = 1'b1; wait_en = 1'b0;
    @(negedge clk);
    ext_byte(16'h0460, 1'b0, 8'hA5, 1, "R5 read", s);
    check(s == 1, "R5 read stall count", s, 1);
    ext_byte(16'hFFFF, 1'b1, 8'h96, 1, "R5 write", s);
    check(s == 1, "R5 write stall count", s, 1);
    req = 1'b0;
  endtask

  task automatic t_ext_wait();
    int s;
    ext_en = 1'b1; wait_en = 1'b1;
    @(negedge clk);
    ext_byte(16'h8001, 1'b0, 8'h5C, 2, "R6 read", s);
    check(s == 2, "R6 read stall count", s, 2);
    ext_byte(16'h1234, 1'b1, 8'h71, 2, "R6 write", s);
    check(s == 2, "R6 write stall count", s, 2);
    req = 1'b0; wait_en = 1'b0;
  endtask

  task automatic t_two_byte(input logic wt);
    int s0, s1, n;
    n = wt ? 2 : 1;
    ext_en = 1'b1; wait_en = wt;
    @(negedge clk);
    ext_byte(16'hF000, 1'b1, 8'h12, n, "R11 push lo", s0);
    ext_byte(16'hEFFF, 1'b1, 8'h34, n, "R11 push hi", s1);
    check(s0 + s1 == 2 * n, "R11 two-byte stall total", s0 + s1, 2 * n);
    ext_byte(16'hEFFF, 1'b0, 8'h34, n, "R11 pop hi", s0);
    ext_byte(16'hF000, 1'b0, 8'h12, n, "R11 pop lo", s1);
    check(s0 + s1 == 2 * n, "R11 two-byte pop total", s0 + s1, 2 * n);
    req = 1'b0; wait_en = 1'b0;
  endtask

  task automatic t_disabled();
    ext_en = 1'b0; wait_en = 1'b1;
    xd_in = 8'hEE;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 16'h0460;
    #2;
    check(ready == 1'b1, "R9 read no stall", ready, 1);
    check(rdata == 8'h00, "R9 read zero", rdata, 0);
    check({rf_sel, io_sel, sram_sel} == 3'b000, "R12 ext no select", {rf_sel, io_sel, sram_sel}, 0);
    @(negedge clk);
    we = 1'b1; addr = 16'hC000; wdata = 8'hAB;
    #2;
    check(ready && xrd_n && xwr_n && !xd_oe && !loc_we, "R9 write ignored",
          {ready, xrd_n, xwr_n, xd_oe, loc_we}, 5'b11100);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    #2;
    check(xwr_n && !xd_oe, "R9 no late write", {xwr_n, xd_oe}, 2'b10);
    wait_en = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ext_en = 1'b0; wait_en = 1'b0; req = 1'b0; we = 1'b0;
    addr = '0; wdata = '0; xd_in = '0;
    rf_rdata = 8'h11; io_rdata = 8'h22; sram_rdata = 8'h33;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_internal(16'h0000, 1'b0, 3'b100, 10'h000, 8'h11, "R1 rf low");
    t_internal(16'h001F, 1'b0, 3'b100, 10'h01F, 8'h11, "R1 rf high");
    t_internal(16'h0020, 1'b0, 3'b010, 10'h000, 8'h22, "R2 io low");
    t_internal(16'h005F, 1'b1, 3'b010, 10'h03F, 8'h22, "R2 io high");
    t_internal(16'h0060, 1'b0, 3'b001, 10'h000, 8'h33, "R3 sram low");
    t_internal(16'h045F, 1'b1, 3'b001, 10'h3FF, 8'h33, "R3 sram high");
    ext_en = 1'b1;
    t_internal(16'h0300, 1'b0, 3'b001, 10'h2A0, 8'h33, "R4 sram with ext on");
    t_ext_nowait();
    t_ext_wait();
    t_two_byte(1'b0);
    t_two_byte(1'b1);
    t_disabled();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule